// File: doc/BRIEF.md
# Clocked Pull-Bias Latch Sequencer

This block holds the pull-resistor setting of every pad in a GPIO pad ring, using the older two-step programming style. Software first writes a requested pull code into one shared code register. After a settling time it raises the clock bit of each pin that should take the code. A pin's stored bias changes only on the 0-to-1 transition of its own clock bit. Software then lowers the bit again. The stored bias of each pin drives a pull-up enable and a pull-down enable toward its pad.

The clock bits are packed into per-bank 32-bit registers. Bank `b` holds pins `32*b` to `32*b+31`, and bit `n` of bank `b` is pin `32*b+n`. A small timer state machine enforces the settling time that must pass between a code write and a capture. It has two states:

- **ARMED**: captures are allowed.
- **SETTLING**: entered on any code write. The machine returns to ARMED once `SETUP_CYC` cycles have passed since that write.

A rising clock bit that arrives while the window is still open does not capture. Instead it sets a sticky `setup_err` flag. The bus is a simple single-cycle, write-only 32-bit interface.

Top module: `pull_latch_seq`

## Requirements
- R1: A write to byte address 0x94 stores `bus_wdata[1:0]` as the shared pull code and discards bits 31:2. A code write by itself never changes any pad output.
- R2: Bank `b` has its clock register at byte address 0x98 + 4*b, and bit `n` of that register belongs to pin 32*b+n. Bits that map to pins at or beyond `NPINS` are not stored.
- R3: When a clock bit goes from 0 to 1 and the setup window is met, the pin stores the shared code. The new pad value is visible from the cycle after the write. One write can capture several pins of the same bank at once.
- R4: The pad state of a pin does not change in any of these cases:
  - its clock bit is rewritten as 1 while it is already 1;
  - its clock bit falls from 1 to 0;
  - `bus_wr` is low.
- R5: Pull codes have fixed meanings:
  - 0 means off;
  - 1 means pull-down, which drives `pad_pull_dn` high;
  - 2 means pull-up, which drives `pad_pull_up` high;
  - 3 is invalid and is stored as off.
  
  The two pad enables of a pin are never high together.
- R6: A clock-bit rising edge at the edge k cycles after the last code write is handled as follows:
  - If k < `SETUP_CYC`, no pin changes and `setup_err` is set.
  - If k = `SETUP_CYC` or more, the capture is accepted.
  
  In both cases the clock register still takes the written value.
- R7: `setup_err` is sticky and is cleared only by reset.
- R8: Reset sets every pin to off, clears the code and all clock registers, clears `setup_err` and puts the timer in ARMED.
- R9: Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| pad_pull_up | output | NPINS | Per-pin pull-up enable |
| pad_pull_dn | output | NPINS | Per-pin pull-down enable |
| setup_err | output | 1 | Sticky setup-window violation flag |

## Verification
The bench keeps `NPINS` at 54, so the second bank is only partly populated (22 pins). It lowers `SETUP_CYC` to 6. With that value, clock writes placed exactly `SETUP_CYC-1` and `SETUP_CYC` cycles after a code write probe both sides of the setup boundary within a few cycles. Full-bank writes to the partial bank exercise the top-pin edge, and a mid-run reset confirms that the clock registers really return to zero.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;
    typedef enum logic [0:0] {
        ST_ARMED    = 1'b0,
        ST_SETTLING = 1'b1
    } timer_state_t;

    localparam logic [1:0] PULL_OFF  = 2'd0;
    localparam logic [1:0] PULL_DOWN = 2'd1;
    localparam logic [1:0] PULL_UP   = 2'd2;

    function automatic logic [1:0] sanitize_code(input logic [1:0] c);
        return (c == 2'd3) ? PULL_OFF : c;
    endfunction
endpackage

// File: rtl/pb_setup_fsm.sv
module pb_setup_fsm
    import pull_seq_pkg::*;
#(
    parameter int SETUP_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic code_wr,
    output logic ready
);
    localparam int CW = $clog2(SETUP_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETUP_CYC - 1);

    timer_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: code write -> SETTLING, count exhausted -> ARMED
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ARMED: begin
                if (code_wr) begin
                    state_d = ST_SETTLING;
                    cnt_d   = LOAD;
                end
            end
            ST_SETTLING: begin
                if (code_wr) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_ARMED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ARMED:    ready = 1'b1;
            ST_SETTLING: ready = (cnt_q == '0);
            default:     ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/pb_clk_bank.sv
module pb_clk_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rise
);
    logic [W-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     bits_q <= '0;
        else if (wr_en) bits_q <= wdata;
    end

    assign rise = wr_en ? (wdata & ~bits_q) : '0;
endmodule

// File: rtl/pull_latch_seq.sv
module pull_latch_seq
    import pull_seq_pkg::*;
#(
    parameter int              NPINS     = 54,
    parameter int              SETUP_CYC = 150,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CODE_ADDR = 8'h94,
    parameter logic [ADDR_W-1:0] CLK_BASE  = 8'h98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [NPINS-1:0]  pad_pull_up,
    output logic [NPINS-1:0]  pad_pull_dn,
    output logic              setup_err
);
    localparam int NBANKS = (NPINS + 31) / 32;

    logic             code_wr;
    logic [1:0]       code_q;
    logic             setup_ready;
    logic [NPINS-1:0] rise_all;
    logic [1:0]       pin_q [NPINS];

    assign code_wr = bus_wr && (bus_addr == CODE_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= PULL_OFF;
        else if (code_wr) code_q <= bus_wdata[1:0];
    end

    pb_setup_fsm #(.SETUP_CYC(SETUP_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .code_wr(code_wr), .ready(setup_ready)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam int BW = (b == NBANKS - 1) ? (NPINS - 32 * b) : 32;
        localparam logic [ADDR_W-1:0] BADDR = ADDR_W'(CLK_BASE + 4 * b);
        logic [BW-1:0] rise_b;
        pb_clk_bank #(.W(BW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bus_wr && (bus_addr == BADDR)),
            .wdata(bus_wdata[BW-1:0]),
            .rise(rise_b)
        );
        assign rise_all[32*b +: BW] = rise_b;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n)
                pin_q[p] <= PULL_OFF;
            else if (rise_all[p] && setup_ready)
                pin_q[p] <= sanitize_code(code_q);
        end
        assign pad_pull_up[p] = (pin_q[p] == PULL_UP);
        assign pad_pull_dn[p] = (pin_q[p] == PULL_DOWN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          setup_err <= 1'b0;
        else if ((|rise_all) && !setup_ready) setup_err <= 1'b1;
    end
endmodule

// File: rtl/pull_latch_seq_chk.sv
module pull_latch_seq_chk #(
    parameter int              NPINS     = 54,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CODE_ADDR = 8'h94
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  pad_pull_up,
    input logic [NPINS-1:0]  pad_pull_dn,
    input logic              setup_err,
    input logic [NPINS-1:0]  rise_all,
    input logic              ready
);
    // R5: the two enables of a pin are exclusive
    a_r5_exclusive_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_up & pad_pull_dn) == '0);

    // R7: violation flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        setup_err |=> setup_err);

    // R4: no bus write, no pad change
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pad_pull_up) && $stable(pad_pull_dn)));

    // R1: a code write never moves a pad
    a_r1_code_write_no_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CODE_ADDR) |=> ($stable(pad_pull_up) && $stable(pad_pull_dn)));

    // R6: edge inside the window is dropped and flagged
    a_r6_early_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rise_all) && !ready) |=> ($stable(pad_pull_up) && $stable(pad_pull_dn) && setup_err));
endmodule

bind pull_latch_seq pull_latch_seq_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .CODE_ADDR(CODE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .setup_err(setup_err), .rise_all(rise_all), .ready(setup_ready)
);

// File: tb/pull_latch_seq_tb.sv
module pull_latch_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 54;
    localparam int S  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [NP-1:0] pad_pull_up, pad_pull_dn;
    logic        setup_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pull_latch_seq #(.NPINS(NP), .SETUP_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pad_pull_up(pad_pull_up),
        .pad_pull_dn(pad_pull_dn), .setup_err(setup_err)
    );

    // behavioural reference model
    int          m_pin [NP];
    logic [31:0] m_clk [2];
    int          m_code;
    longint      cyc = 0;
    longint      last_code = -1000;
    bit          m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) m_pin[i] = 0;
            m_clk[0] = 0; m_clk[1] = 0; m_code = 0; m_err = 0;
            last_code = -1000;
        end else if (bus_wr) begin
            if (bus_addr == 8'h94) begin
                m_code = int'(bus_wdata[1:0]);
                last_code = cyc;
            end else begin
                for (int b = 0; b < 2; b++) begin
                    if (bus_addr == 8'(8'h98 + 4 * b)) begin
                        for (int n = 0; n < 32; n++) begin
                            if (32 * b + n < NP && bus_wdata[n] && !m_clk[b][n]) begin
                                if (cyc - last_code >= S)
                                    m_pin[32 * b + n] = (m_code == 3) ? 0 : m_code;
                                else
                                    m_err = 1;
                            end
                        end
                        m_clk[b] = bus_wdata;
                    end
                end
            end
        end
        cyc++;
    end

    function automatic int pin_state(int p);
        return pad_pull_up[p] ? 2 : (pad_pull_dn[p] ? 1 : 0);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R3, R5, R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int bad;
            bad = 0;
            for (int p = 0; p < NP; p++)
                if (pin_state(p) != m_pin[p]) bad++;
            check("R3/R5 model pad compare", bad, 0);
            check("R6 model setup_err compare", int'(setup_err), int'(m_err));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R8 reset state
        check("R8 reset pull_up", int'(|pad_pull_up), 0);
        check("R8 reset pull_dn", int'(|pad_pull_dn), 0);
        check("R8 reset setup_err", int'(setup_err), 0);

        // R1: upper bits discarded, no pad change
        wr(8'h94, 32'hFFFF_FFF2);
        check("R1 code write no pad change", int'(|pad_pull_up), 0);
        idle(S - 1);
        wr(8'h98, 32'h20);                  // k = S
        check("R3 pin5 pull-up", pin_state(5), 2);
        check("R3 pin4 untouched", pin_state(4), 0);

        // R4 held bit and falling bit
        wr(8'h94, 32'h1);
        idle(S);
        wr(8'h98, 32'h20);
        check("R4 held bit no capture", pin_state(5), 2);
        wr(8'h98, 32'h0);
        check("R4 falling bit no capture", pin_state(5), 2);
        wr(8'h98, 32'h20);
        check("R3 recapture pull-down", pin_state(5), 1);

        // R2 bank 1 mapping, partial bank
        wr(8'h9C, 32'h100);
        check("R2 pin40 via bank1 bit8", pin_state(40), 1);
        check("R2 pin8 untouched", pin_state(8), 0);
        wr(8'h9C, 32'hFFFF_FFFF);
        check("R2 top pin53 captured", pin_state(53), 1);
        check("R2 bank0 pin31 untouched", pin_state(31), 0);

        // R5 code 3 stored as off
        wr(8'h9C, 32'h0);
        wr(8'h94, 32'h3);
        idle(S);
        wr(8'h9C, 32'h100);
        check("R5 code3 -> off", pin_state(40), 0);
        check("R5 pin41 kept", pin_state(41), 1);

        // R6 boundary k = S accepted
        wr(8'h94, 32'h2);
        idle(S - 1);
        wr(8'h98, 32'h60);
        check("R6 k=S accepted", pin_state(6), 2);
        check("R6 no flag at k=S", int'(setup_err), 0);

        // R6 k = S-1 rejected, flag set, register still updated
        wr(8'h94, 32'h1);
        idle(S - 2);
        wr(8'h98, 32'h70);
        check("R6 k=S-1 ignored", pin_state(4), 0);
        check("R6 flag set", int'(setup_err), 1);
        idle(S);
        wr(8'h98, 32'h70);
        check("R6 register updated on early write", pin_state(4), 0);

        // R9 other addresses ignored
        wr(8'hA0, 32'hFFFF_FFFF);
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h95, 32'h2);
        check("R9 stray writes no pad change", pin_state(0), 0);
        wr(8'h98, 32'h7F);                  // pins 0..3 rise together, code still 1
        check("R9 code untouched by stray writes", pin_state(0), 1);
        check("R3 multi-pin capture", pin_state(3), 1);
        idle(3);
        check("R7 flag still set", int'(setup_err), 1);

        // R8 mid-run reset clears clock registers
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R8 reset pins off", int'(|pad_pull_dn), 0);
        check("R8 reset flag clear", int'(setup_err), 0);
        wr(8'h94, 32'h2);
        idle(S);
        wr(8'h98, 32'h20);
        check("R8 clock register cleared", pin_state(5), 2);
        idle(2);
        finish_run();
    end
endmodule